// File: doc/BRIEF.md
# Privilege-Checked Segment Address Decoder

This block sorts a 32-bit virtual address into one of five fixed segments. Depending on the segment, the current privilege mode and the error-level status bit, it then does one of three things. It translates the address directly to a physical address, it asks the translation lookaside buffer (TLB) to map it, or it reports an address error. The decoder is purely combinational, so it can sit in front of a TLB in the same cycle as the address computation.

Direct translations apply in three cases:
- the low segment while the error-level bit is set, which is an identity mapping;
- the first kernel window, which drops the top address bit;
- the second kernel window, which drops the top three address bits.

Direct translations always grant read and write permission. The two upper segments are always sent to the TLB, provided the current mode may use them. A segment the current mode may not use produces an error and no address. The access type only selects whether that error is reported as a store fault.

Top module: `segAddrDecode`

## Requirements
- R1: With the error-level bit clear, any address 0x00000000..0x7FFFFFFF in any mode raises tlbReq only; physAddr is 0 and both permissions are 0.
- R2: With the error-level bit set, any address 0x00000000..0x7FFFFFFF in any mode raises directOk with physAddr equal to the virtual address and permRd = permWr = 1.
- R3: In kernel mode, addresses 0x80000000..0x9FFFFFFF raise directOk with physAddr = address - 0x80000000.
- R4: In kernel mode, addresses 0xA0000000..0xBFFFFFFF raise directOk with physAddr = address - 0xA0000000.
- R5: In user (privMode = 2'b10) or supervisor (privMode = 2'b01) mode, addresses 0x80000000..0xBFFFFFFF raise addrErr only, with physAddr 0 and no permissions.
- R6: Addresses 0xC0000000..0xDFFFFFFF raise tlbReq in supervisor or kernel mode and addrErr in user mode.
- R7: Addresses 0xE0000000..0xFFFFFFFF raise tlbReq in kernel mode and addrErr in user or supervisor mode.
- R8: Both privMode = 2'b00 and privMode = 2'b11 behave as kernel mode.
- R9: For every input, exactly one of directOk, tlbReq and addrErr is 1. permRd and permWr both equal directOk.
- R10: errStore equals addrErr AND isStore (isStore = 1 marks a write). The access type has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| virtAddr | input | 32 | Virtual address to decode |
| isStore | input | 1 | Access type: 1 for a write, 0 for a read |
| privMode | input | 2 | 2'b10 user, 2'b01 supervisor, 2'b00 or 2'b11 kernel |
| errLevel | input | 1 | Error-level status bit; makes the low segment an identity mapping |
| physAddr | output | 32 | Physical address for direct translations, otherwise 0 |
| directOk | output | 1 | Address translated directly |
| tlbReq | output | 1 | Address must be looked up in the TLB |
| addrErr | output | 1 | Access not allowed in the current mode |
| errStore | output | 1 | Address error raised by a write |
| permRd | output | 1 | Read permission granted |
| permWr | output | 1 | Write permission granted |

## Verification
The bench builds the decoder with its default 32-bit address width. At that width every segment boundary is a concrete value, so the bench can check addresses on either side of 0x80000000, 0xA0000000, 0xC0000000 and 0xE0000000. It checks these boundaries and the extreme addresses 0 and 0xFFFFFFFF under all four mode codes, both error-level values and both access types. It then compares a long run of mixed inputs, biased toward boundaries, against a behavioural model that uses plain subtraction for the kernel windows.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  typedef enum logic [1:0] {
    MODE_KERN     = 2'b00,
    MODE_SUP      = 2'b01,
    MODE_USER     = 2'b10,
    MODE_KERN_ALT = 2'b11
  } privMode_e;

  // strobes from control to datapath, at most one set
  typedef struct packed {
    logic identity;  // pass address unchanged
    logic strip1;    // clear top bit
    logic strip3;    // clear top three bits
    logic lookup;    // hand to TLB
    logic fault;     // address error
  } segStrobe_t;
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic [2:0] vaTop,
  input  logic [1:0] privMode,
  input  logic       errLevel,
  output segStrobe_t strobe
);
  logic isUser, isSup, isKern;

  always_comb begin
    isUser = (privMode == MODE_USER);
    isSup  = (privMode == MODE_SUP);
    isKern = !isUser && !isSup;
  end

  always_comb begin
    strobe = '0;
    casez (vaTop)
      3'b0??: begin
        if (errLevel) strobe.identity = 1'b1;
        else          strobe.lookup   = 1'b1;
      end
      3'b100: begin
        if (isKern) strobe.strip1 = 1'b1;
        else        strobe.fault  = 1'b1;
      end
      3'b101: begin
        if (isKern) strobe.strip3 = 1'b1;
        else        strobe.fault  = 1'b1;
      end
      3'b110: begin
        if (isKern || isSup) strobe.lookup = 1'b1;
        else                 strobe.fault  = 1'b1;
      end
      default: begin
        if (isKern) strobe.lookup = 1'b1;
        else        strobe.fault  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] virtAddr,
  input  logic              isStore,
  input  segStrobe_t        strobe,
  output logic [ADDR_W-1:0] physAddr,
  output logic              directOk,
  output logic              tlbReq,
  output logic              addrErr,
  output logic              errStore,
  output logic              permRd,
  output logic              permWr
);
  localparam int LOW1_W = ADDR_W - 1;
  localparam int LOW3_W = ADDR_W - 3;

  logic [ADDR_W-1:0] k0Addr, k1Addr;

  always_comb begin
    k0Addr = {1'b0, virtAddr[LOW1_W-1:0]};
    k1Addr = {3'b000, virtAddr[LOW3_W-1:0]};
  end

  always_comb begin
    physAddr = '0;
    if (strobe.identity)    physAddr = virtAddr;
    else if (strobe.strip1) physAddr = k0Addr;
    else if (strobe.strip3) physAddr = k1Addr;
  end

  always_comb begin
    directOk = strobe.identity | strobe.strip1 | strobe.strip3;
    tlbReq   = strobe.lookup;
    addrErr  = strobe.fault;
    errStore = strobe.fault & isStore;
    permRd   = directOk;
    permWr   = directOk;
  end
endmodule

// File: rtl/segAddrDecode.sv
module segAddrDecode
  import segdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] virtAddr,
  input  logic              isStore,
  input  logic [1:0]        privMode,
  input  logic              errLevel,
  output logic [ADDR_W-1:0] physAddr,
  output logic              directOk,
  output logic              tlbReq,
  output logic              addrErr,
  output logic              errStore,
  output logic              permRd,
  output logic              permWr
);
  localparam int TOP_MSB = ADDR_W - 1;

  segStrobe_t strobe;

  segdec_ctrl u_ctrl (
    .vaTop    (virtAddr[TOP_MSB -: 3]),
    .privMode (privMode),
    .errLevel (errLevel),
    .strobe   (strobe)
  );

  segdec_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .virtAddr (virtAddr),
    .isStore  (isStore),
    .strobe   (strobe),
    .physAddr (physAddr),
    .directOk (directOk),
    .tlbReq   (tlbReq),
    .addrErr  (addrErr),
    .errStore (errStore),
    .permRd   (permRd),
    .permWr   (permWr)
  );
endmodule

// File: rtl/segAddrDecode_chk.sv
module segAddrDecode_chk #(
  parameter int ADDR_W = 32
) (
  input logic [ADDR_W-1:0] virtAddr,
  input logic              isStore,
  input logic [1:0]        privMode,
  input logic              errLevel,
  input logic [ADDR_W-1:0] physAddr,
  input logic              directOk,
  input logic              tlbReq,
  input logic              addrErr,
  input logic              errStore,
  input logic              permRd,
  input logic              permWr
);
  always_comb begin
    assert_one_outcome_R9: assert ($countones({directOk, tlbReq, addrErr}) == 1);
    assert_perm_direct_R9: assert (permRd == directOk && permWr == directOk);
    assert_err_no_addr_R5: assert (!addrErr || physAddr == '0);
    assert_low_seg_R1: assert (virtAddr[ADDR_W-1] || errLevel || tlbReq);
    assert_identity_R2: assert (virtAddr[ADDR_W-1] || !errLevel || physAddr == virtAddr);
    assert_user_fault_R7: assert (!(privMode == 2'b10 && virtAddr[ADDR_W-1]) || addrErr);
    assert_store_flag_R10: assert (errStore == (addrErr && isStore));
  end
endmodule

bind segAddrDecode segAddrDecode_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/segAddrDecode_tb.sv
module segAddrDecode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] virtAddr = '0;
  logic        isStore = 1'b0;
  logic [1:0]  privMode = 2'b00;
  logic        errLevel = 1'b0;
  logic [31:0] physAddr;
  logic        directOk, tlbReq, addrErr, errStore, permRd, permWr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segAddrDecode #(.ADDR_W(32)) u_dut (
    .virtAddr(virtAddr), .isStore(isStore), .privMode(privMode), .errLevel(errLevel),
    .physAddr(physAddr), .directOk(directOk), .tlbReq(tlbReq), .addrErr(addrErr),
    .errStore(errStore), .permRd(permRd), .permWr(permWr)
  );

  // behavioural reference model
  task automatic checkNow();
    longint unsigned va;
    bit user, sup, kern;
    bit eDir, eTlb, eErr;
    longint unsigned ePhys;
    string tag;
    va = longint'(virtAddr);
    user = (privMode == 2'b10);
    sup  = (privMode == 2'b01);
    kern = !(user || sup);            // R8
    eDir = 0; eTlb = 0; eErr = 0; ePhys = 0;
    if (va < 64'h8000_0000) begin
      if (errLevel) begin eDir = 1; ePhys = va; tag = "R2"; end
      else begin eTlb = 1; tag = "R1"; end
    end else if (va < 64'hA000_0000) begin
      if (kern) begin eDir = 1; ePhys = va - 64'h8000_0000; tag = "R3"; end
      else begin eErr = 1; tag = "R5"; end
    end else if (va < 64'hC000_0000) begin
      if (kern) begin eDir = 1; ePhys = va - 64'hA000_0000; tag = "R4"; end
      else begin eErr = 1; tag = "R5"; end
    end else if (va < 64'hE000_0000) begin
      tag = "R6";
      if (user) eErr = 1; else eTlb = 1;
    end else begin
      tag = "R7";
      if (kern) eTlb = 1; else eErr = 1;
    end
    if (privMode == 2'b11 || privMode == 2'b00) tag = {tag, "/R8"};
    checks++;
    if (directOk !== eDir || tlbReq !== eTlb || addrErr !== eErr ||
        physAddr !== 32'(ePhys)) begin
      errors++;
      $display("FAIL %s va=%h mode=%b erl=%b: got dir=%b tlb=%b err=%b pa=%h exp dir=%b tlb=%b err=%b pa=%h",
               tag, virtAddr, privMode, errLevel, directOk, tlbReq, addrErr, physAddr,
               eDir, eTlb, eErr, 32'(ePhys));
    end
    checks++;
    if (permRd !== eDir || permWr !== eDir) begin   // R9
      errors++;
      $display("FAIL R9 va=%h: got rd=%b wr=%b exp %b", virtAddr, permRd, permWr, eDir);
    end
    checks++;
    if (errStore !== (eErr && isStore)) begin       // R10
      errors++;
      $display("FAIL R10 va=%h st=%b: got errStore=%b exp %b", virtAddr, isStore, errStore,
               eErr && isStore);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] m, input logic e, input logic s);
    @(posedge clk);
    #1;
    virtAddr = a; privMode = m; errLevel = e; isStore = s;
    @(negedge clk);
    checkNow();
  endtask

  initial begin
    logic [31:0] edges [12];
    edges = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
              32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
              32'hE000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8ABC_DEF0};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs select the TLB (R1)
    @(negedge clk);
    checkNow();
    for (int i = 0; i < 12; i++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int s = 0; s < 2; s++)
            apply(edges[i], 2'(m), 1'(e), 1'(s));
    for (int n = 0; n < RAND_CYCLES; n++) begin
      logic [31:0] a;
      a = $urandom;
      if (n % 3 == 0) a = {a[31:29], (a[0] ? 29'h1FFF_FFFF : 29'h0)};
      apply(a, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: got hang exp completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule